// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short record of how finished transmissions ended, so the host can inspect them at its own pace. Each time the transmit engine reports a finished frame, it raises a one-cycle completion strobe together with flags for: the interrupt-on-success request, a jabber error, an underrun and too many collisions. The block turns that report into an 8-bit status byte. It stores the byte in a small store whose depth is a parameter (4 by default).

The host always sees the oldest stored byte on the status output, and a write strobe from the host discards it. The completion strobe has no back-pressure: every report is taken in the cycle it appears. When the store is already full, the new byte is dropped and its loss is flagged in the newest byte still held. A jabber or underrun raises a transmit-reset request that keeps the transmitter stopped. Only a transmit reset clears it, and that reset also empties the store. A pending flag tells the interrupt unit that at least one byte is waiting.

Top module: `txdone_status_stack`

## Requirements
- R1: A stored status byte has bit 7 = 1 (done), bit 6 = interrupt-on-success request, bit 5 = jabber, bit 4 = underrun, bit 3 = too many collisions, bit 2 = status overflow, and bits 1..0 = 0.
- R2: A completion with no error flag is stored only when its interrupt-on-success flag is 1. A completion with any error flag is always stored.
- R3: `stat_byte` shows the oldest stored byte, and a `host_pop` strobe removes it, so bytes leave in the order they arrived.
- R4: While the store is empty, `stat_byte` reads 0x00, and `host_pop` has no effect.
- R5: `txc_pending` is 1 exactly when at least one byte is stored.
- R6: A completion that must be stored while the store is full and no pop occurs in the same cycle is dropped. Bit 2 is then set in the newest byte already held.
- R7: A completion with jabber or underrun sets `txrst_req` one cycle later. The request then stays set until a transmit reset.
- R8: A `tx_reset` strobe empties the store and clears `txrst_req` in the next cycle. A completion in the same cycle is discarded.
- R9: A completion and a pop in the same cycle on a full store both take effect, and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | One-cycle completion strobe from the transmit engine |
| cmp_intreq | input | 1 | Interrupt on success was requested for this frame |
| cmp_jabber | input | 1 | Jabber error |
| cmp_underrun | input | 1 | Underrun error |
| cmp_maxcoll | input | 1 | Too many collisions |
| host_pop | input | 1 | Host write strobe that discards the oldest byte |
| tx_reset | input | 1 | Transmit reset strobe |
| stat_byte | output | 8 | Oldest stored status byte, 0x00 when empty |
| txc_pending | output | 1 | At least one byte stored |
| txrst_req | output | 1 | Transmitter stopped until a transmit reset |

## Verification
The bench builds the block with a depth of 3, which is not a power of two. This makes the read and write positions wrap at a non-binary boundary, and it lets the full-store cases be reached after only three reports. With that depth, the bench reaches an overflow that marks the newest byte, and a same-cycle store-and-discard on a full store. It also sends a transmit reset together with a completion, and checks each case against a queue model on every clock.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int STAT_W  = 8;
  localparam int B_DONE  = 7;
  localparam int B_INTRQ = 6;
  localparam int B_JAB   = 5;
  localparam int B_UND   = 4;
  localparam int B_MAXC  = 3;
  localparam int B_OVF   = 2;
endpackage

// File: rtl/txs_entry_fmt.sv
module txs_entry_fmt
  import txs_pkg::*;
(
  input  logic              cmp_valid,
  input  logic              cmp_intreq,
  input  logic              cmp_jabber,
  input  logic              cmp_underrun,
  input  logic              cmp_maxcoll,
  output logic              need_push,
  output logic              halt_set,
  output logic [STAT_W-1:0] entry
);
  logic any_err;

  always_comb begin
    any_err   = cmp_jabber | cmp_underrun | cmp_maxcoll;
    need_push = cmp_valid & (any_err | cmp_intreq);
    halt_set  = cmp_valid & (cmp_jabber | cmp_underrun);
    entry          = '0;
    entry[B_DONE]  = 1'b1;
    entry[B_INTRQ] = cmp_intreq;
    entry[B_JAB]   = cmp_jabber;
    entry[B_UND]   = cmp_underrun;
    entry[B_MAXC]  = cmp_maxcoll;
  end
endmodule

// File: rtl/txs_store.sv
module txs_store
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [STAT_W-1:0] din,
  input  logic              pop,
  output logic [STAT_W-1:0] dout,
  output logic              not_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [STAT_W-1:0] slot [DEPTH];
  logic [PW-1:0]     wp, rp, tail;
  logic [CW-1:0]     cnt;
  logic              full, empty, pop_ok, push_ok, ovf;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    empty   = (cnt == '0);
    full    = (cnt == CW'(DEPTH));
    pop_ok  = pop & ~empty;
    push_ok = push & (~full | pop_ok);
    ovf     = push & full & ~pop_ok;
    tail    = (wp == '0) ? PW'(DEPTH - 1) : wp - PW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (!clr && push_ok && wp == PW'(i))
        slot[i] <= din;
      else if (!clr && ovf && tail == PW'(i))
        slot[i][B_OVF] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      if (push_ok && !pop_ok)      cnt <= cnt + CW'(1);
      else if (pop_ok && !push_ok) cnt <= cnt - CW'(1);
    end
  end

  assign dout      = empty ? '0 : slot[rp];
  assign not_empty = ~empty;

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> (cnt == '0));
  // R9
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && push && !clr) |=> (cnt == CW'(DEPTH)));
endmodule

// File: rtl/txs_halt_ctl.sv
module txs_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   req <= 1'b0;
    else if (clr) req <= 1'b0;
    else if (set) req <= 1'b1;
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !clr) |=> req);
  // R8
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !req);
endmodule

// File: rtl/txdone_status_stack.sv
module txdone_status_stack
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              cmp_intreq,
  input  logic              cmp_jabber,
  input  logic              cmp_underrun,
  input  logic              cmp_maxcoll,
  input  logic              host_pop,
  input  logic              tx_reset,
  output logic [STAT_W-1:0] stat_byte,
  output logic              txc_pending,
  output logic              txrst_req
);
  logic              need_push, halt_set;
  logic [STAT_W-1:0] entry;

  txs_entry_fmt u_fmt (
    .cmp_valid(cmp_valid), .cmp_intreq(cmp_intreq), .cmp_jabber(cmp_jabber),
    .cmp_underrun(cmp_underrun), .cmp_maxcoll(cmp_maxcoll),
    .need_push(need_push), .halt_set(halt_set), .entry(entry)
  );

  txs_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(tx_reset), .push(need_push), .din(entry),
    .pop(host_pop), .dout(stat_byte), .not_empty(txc_pending)
  );

  txs_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .set(halt_set), .clr(tx_reset), .req(txrst_req)
  );

  // R1
  byte_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[1:0] == 2'b00) && (stat_byte == '0 || stat_byte[B_DONE]));
  // R5
  pending_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_pending) |-> $past(cmp_valid));
endmodule

// File: tb/test_txdone_status_stack.sv
module test_txdone_status_stack;
  localparam int D = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_valid = 0, cmp_intreq = 0, cmp_jabber = 0, cmp_underrun = 0, cmp_maxcoll = 0;
  logic host_pop = 0, tx_reset = 0;
  logic [7:0] stat_byte;
  logic txc_pending, txrst_req;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txdone_status_stack #(.DEPTH(D)) i_txdone_status_stack (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_intreq(cmp_intreq),
    .cmp_jabber(cmp_jabber), .cmp_underrun(cmp_underrun), .cmp_maxcoll(cmp_maxcoll),
    .host_pop(host_pop), .tx_reset(tx_reset), .stat_byte(stat_byte),
    .txc_pending(txc_pending), .txrst_req(txrst_req)
  );

  // reference model
  logic [7:0] mq[$];
  bit m_req = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_req = 0;
    end else if (tx_reset) begin
      mq.delete(); m_req = 0;
    end else begin
      bit need, popped;
      logic [7:0] e;
      need = cmp_valid && (cmp_intreq || cmp_jabber || cmp_underrun || cmp_maxcoll);
      e = {1'b1, cmp_intreq, cmp_jabber, cmp_underrun, cmp_maxcoll, 3'b000};
      if (cmp_valid && (cmp_jabber || cmp_underrun)) m_req = 1;
      popped = host_pop && mq.size() > 0;
      if (popped) void'(mq.pop_front());
      if (need) begin
        if (mq.size() < D) mq.push_back(e);
        else mq[mq.size()-1][2] = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison
  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] eb;
    eb = (mq.size() > 0) ? mq[0] : 8'h00;
    chk(stat_byte === eb, "R3 stat_byte", stat_byte, eb);
    chk(txc_pending === (mq.size() > 0), "R5 txc_pending", txc_pending, int'(mq.size() > 0));
    chk(txrst_req === m_req, "R7 txrst_req", txrst_req, m_req);
  end

  task automatic step(input bit v, input bit ir, input bit j, input bit u,
                      input bit m, input bit p, input bit r);
    cmp_valid = v; cmp_intreq = ir; cmp_jabber = j; cmp_underrun = u;
    cmp_maxcoll = m; host_pop = p; tx_reset = r;
    @(negedge clk);
    cmp_valid = 0; cmp_intreq = 0; cmp_jabber = 0; cmp_underrun = 0;
    cmp_maxcoll = 0; host_pop = 0; tx_reset = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat_byte == 8'h00 && !txc_pending && !txrst_req, "R4 reset state", stat_byte, 0);

    step(1,0,0,0,0,0,0);
    chk(!txc_pending, "R2 silent success not stored", txc_pending, 0);
    step(1,1,0,0,0,0,0);
    chk(stat_byte == 8'hC0, "R1 success entry", stat_byte, 8'hC0);
    step(1,0,0,0,1,0,0);
    chk(stat_byte == 8'hC0, "R3 oldest stays on top", stat_byte, 8'hC0);
    step(0,0,0,0,0,1,0);
    chk(stat_byte == 8'h88, "R2 error always stored", stat_byte, 8'h88);
    step(0,0,0,0,0,1,0);
    step(0,0,0,0,0,1,0);
    chk(stat_byte == 8'h00 && !txc_pending, "R4 empty pop ignored", stat_byte, 0);

    // fill then overflow
    step(1,1,0,0,0,0,0);
    step(1,0,0,0,1,0,0);
    step(1,1,0,0,0,0,0);
    step(1,0,0,0,1,0,0);
    step(0,0,0,0,0,1,0);
    step(0,0,0,0,0,1,0);
    chk(stat_byte == 8'hC4, "R6 overflow marks newest", stat_byte, 8'hC4);
    step(0,0,0,0,0,1,0);
    chk(!txc_pending, "R6 overflowed entry dropped", txc_pending, 0);

    // full with simultaneous push and pop
    step(1,1,0,0,0,0,0);
    step(1,1,0,0,0,0,0);
    step(1,1,0,0,0,0,0);
    step(1,0,0,0,1,1,0);
    step(0,0,0,0,0,1,0);
    step(0,0,0,0,0,1,0);
    chk(stat_byte == 8'h88, "R9 swap on full, no overflow", stat_byte, 8'h88);
    step(0,0,0,0,0,1,0);

    // halt
    step(1,0,1,0,0,0,0);
    chk(txrst_req && stat_byte == 8'hA0, "R7 jabber halts", stat_byte, 8'hA0);
    repeat (4) step(0,0,0,0,0,0,0);
    chk(txrst_req, "R7 request held", txrst_req, 1);
    step(1,1,0,1,0,0,0);
    step(0,0,0,0,0,1,0);
    chk(stat_byte == 8'hD0, "R1 underrun entry", stat_byte, 8'hD0);
    step(1,0,0,1,0,0,1);
    chk(!txrst_req && !txc_pending && stat_byte == 8'h00, "R8 reset clears", stat_byte, 0);

    // mixed pattern
    for (int k = 0; k < 40; k++)
      step(k % 3 != 0, k % 2, k % 11 == 5, 1'b0, k % 4 == 1, k % 5 < 2, k == 30);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule